// File: doc/BRIEF.md
# Receive DMA Request Controller

This block decides when to ask the host bus for DMA cycles that move a received Ethernet frame out of the receive buffer and into a circular buffer in host memory. It raises a request when a complete frame is waiting. It keeps that request up through the host's acknowledged reads, and it drops the request when the last read of the frame completes. For every completed read it advances a byte offset into the host buffer. The offset wraps at 16 KB or at 64 KB, depending on a size-select input.

The block has two ways of running. In demand mode the request stays high for the whole frame, and the host holds its acknowledge for the whole frame. In single-transfer mode the request drops as soon as the host read strobe falls, so the acknowledge may be released between reads. An optional burst cap limits one continuous stretch of access to about 28 us. After that the block holds the request low for about 1.3 us before it asks again. Both intervals are cycle counts derived from the clock frequency in MHz.

A DMA reset input overrides everything else. In the same cycle it ends any activity in progress, pulses a strobe that clears the receive buffers, and returns the offset to zero.

Top module: `rx_dma_req_ctrl`

## Requirements
- R1: After `rst_ni` is released and while no frame is pending, `dreq_o` is 0, `offset_o` is 0, `buf_clear_o` is 0 and `dma_abort_o` is 0.
- R2: Demand mode (`single_xfer_i`=0). With `frame_avail_i` high, `dreq_o` rises the cycle after the block is idle. It stays high through the acknowledged reads. It falls the cycle after a read completes with `frame_end_i` high.
- R3: With `burst_cap_en_i`=1, `dreq_o` stays high for exactly BURST_CYC = CLK_MHZ*BURST_NS/1000 cycles (3500 by default) and then falls. It then stays low for GAP_CYC+1 cycles, where GAP_CYC = CLK_MHZ*GAP_NS/1000 (162 by default), and `frame_avail_i` is ignored during that time. After this, `dreq_o` rises again if a frame is still pending.
- R4: With `burst_cap_en_i`=0, `dreq_o` stays high without a break until the frame ends.
- R5: Single-transfer mode (`single_xfer_i`=1). `dreq_o` goes low in the same cycle that `rd_n_i` falls (1 sampled, then 0) while `dack_i` is 1. After `rd_n_i` rises again, `dreq_o` returns the next cycle, unless `frame_end_i` was high at that rise.
- R6: `dma_reset_i`=1 does three things:
  - It forces `dreq_o` low in the same cycle.
  - It drives `dma_abort_o` high in that cycle if a transfer or gap was in progress.
  - It sets `offset_o` to 0 the next cycle.
  When `dma_reset_i` rises, `buf_clear_o` is high for exactly one cycle, the cycle after the rise.
- R7: If `dma_reset_i` arrives in the same cycle as a read completion, the reset wins and `offset_o` becomes 0, not offset+XFER_BYTES.
- R8: A read completion is `rd_n_i` sampled 0 and then 1 while `dack_i`=1. Each one adds XFER_BYTES (2) to `offset_o` the next cycle. Nothing else changes `offset_o` except the DMA reset.
- R9: The offset wraps modulo 16384 when `big_buf_i`=0 and modulo 65536 when `big_buf_i`=1.
- R10: While `frame_avail_i` is 0 and the block is idle, `dreq_o` stays 0 whatever the acknowledge and the read strobe do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_cap_en_i | input | 1 | Enables the burst time cap and the forced release gap |
| single_xfer_i | input | 1 | Single-transfer mode; request drops on read strobe fall |
| big_buf_i | input | 1 | Host buffer size: 1 = 64 KB, 0 = 16 KB |
| dma_reset_i | input | 1 | Ends DMA activity, clears buffers, zeroes offset |
| frame_avail_i | input | 1 | A complete received frame is pending |
| frame_end_i | input | 1 | The read now completing is the last of the frame |
| dack_i | input | 1 | Host DMA acknowledge |
| rd_n_i | input | 1 | Host read strobe, active low |
| dreq_o | output | 1 | DMA request |
| offset_o | output | OFS_W (16) | Byte offset into the host receive buffer |
| buf_clear_o | output | 1 | One-cycle strobe that clears the receive buffers |
| dma_abort_o | output | 1 | Terminate strobe to an active receive DMA |

## Verification
Two functions can fall in the same cycle: the DMA reset and the offset step caused by a read completion. The bench provokes this by raising `dma_reset_i` in the same cycle that `rd_n_i` returns high under acknowledge, after first moving the offset away from zero. The result is judged by requiring `offset_o` to read 0 in the next cycle rather than the stepped value. Random frames are also run with both modes and both buffer sizes, and the wrap boundaries are checked directly at 0x3FFE and 0xFFFE.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_HOLD = 2'd2,
    ST_GAP  = 2'd3
  } rxdma_state_e;
endpackage

// File: rtl/rxdma_strobe_edge.sv
module rxdma_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strb_n_i,
  output logic fall_o,
  output logic rise_o
);
  logic strb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strb_q <= 1'b1;
    else         strb_q <= strb_n_i;
  end

  assign fall_o = strb_q & ~strb_n_i;
  assign rise_o = ~strb_q & strb_n_i;
endmodule

// File: rtl/rxdma_interval_timer.sv
module rxdma_interval_timer #(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = run_i & ~clr_i & (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && !done_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rxdma_offset_ptr.sv
module rxdma_offset_ptr #(
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned SMALL_W    = 14,
  parameter int unsigned XFER_BYTES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  input  logic             step_i,
  input  logic             big_i,
  output logic [OFS_W-1:0] ofs_o
);
  localparam logic [OFS_W-1:0] SMALL_MASK = {{(OFS_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};

  logic [OFS_W-1:0] mask;
  assign mask = big_i ? {OFS_W{1'b1}} : SMALL_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ofs_o <= '0;
    else if (zero_i) ofs_o <= '0;  // reset beats a step in the same cycle
    else if (step_i) ofs_o <= (ofs_o + OFS_W'(XFER_BYTES)) & mask;
  end
endmodule

// File: rtl/rx_dma_req_ctrl.sv
module rx_dma_req_ctrl
  import rxdma_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 125,
  parameter int unsigned BURST_NS   = 28000,
  parameter int unsigned GAP_NS     = 1300,
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned SMALL_W    = 14,
  parameter int unsigned XFER_BYTES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             burst_cap_en_i,
  input  logic             single_xfer_i,
  input  logic             big_buf_i,
  input  logic             dma_reset_i,
  input  logic             frame_avail_i,
  input  logic             frame_end_i,
  input  logic             dack_i,
  input  logic             rd_n_i,
  output logic             dreq_o,
  output logic [OFS_W-1:0] offset_o,
  output logic             buf_clear_o,
  output logic             dma_abort_o
);
  localparam int unsigned BURST_CYC = CLK_MHZ * BURST_NS / 1000;
  localparam int unsigned GAP_CYC   = CLK_MHZ * GAP_NS / 1000;

  rxdma_state_e state_q, state_d;
  logic rd_fall, rd_rise, rd_done;
  logic active, burst_expire, gap_done, single_drop;
  logic rst_seen_q, buf_clear_q;

  rxdma_strobe_edge u_rd_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strb_n_i(rd_n_i),
    .fall_o  (rd_fall),
    .rise_o  (rd_rise)
  );

  assign rd_done     = dack_i & rd_rise;
  assign active      = (state_q == ST_REQ) || (state_q == ST_HOLD);
  assign single_drop = single_xfer_i & dack_i & rd_fall;

  rxdma_interval_timer #(.LIMIT(BURST_CYC)) u_burst_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (~active),
    .run_i (active & burst_cap_en_i),
    .done_o(burst_expire)
  );

  rxdma_interval_timer #(.LIMIT(GAP_CYC)) u_gap_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (state_q != ST_GAP),
    .run_i (state_q == ST_GAP),
    .done_o(gap_done)
  );

  rxdma_offset_ptr #(
    .OFS_W     (OFS_W),
    .SMALL_W   (SMALL_W),
    .XFER_BYTES(XFER_BYTES)
  ) u_ofs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .zero_i(dma_reset_i),
    .step_i(rd_done),
    .big_i (big_buf_i),
    .ofs_o (offset_o)
  );

  // priority: dma reset > frame end > burst expiry > single-mode hand-off
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (frame_avail_i && !dma_reset_i) state_d = ST_REQ;
      ST_REQ: begin
        if (dma_reset_i)                                     state_d = ST_IDLE;
        else if (!single_xfer_i && rd_done && frame_end_i)  state_d = ST_IDLE;
        else if (burst_expire)                               state_d = ST_GAP;
        else if (single_drop)                                state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (dma_reset_i)                   state_d = ST_IDLE;
        else if (rd_rise && frame_end_i)   state_d = ST_IDLE;
        else if (burst_expire)             state_d = ST_GAP;
        else if (rd_rise)                  state_d = ST_REQ;
      end
      ST_GAP: begin
        if (dma_reset_i || gap_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      rst_seen_q  <= 1'b0;
      buf_clear_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rst_seen_q  <= dma_reset_i;
      buf_clear_q <= dma_reset_i & ~rst_seen_q;
    end
  end

  assign dreq_o      = (state_q == ST_REQ) & ~dma_reset_i & ~single_drop;
  assign dma_abort_o = dma_reset_i & (state_q != ST_IDLE);
  assign buf_clear_o = buf_clear_q;
endmodule

// File: rtl/rx_dma_req_ctrl_chk.sv
module rx_dma_req_ctrl_chk #(
  parameter int unsigned CLK_MHZ    = 125,
  parameter int unsigned BURST_NS   = 28000,
  parameter int unsigned OFS_W      = 16,
  parameter int unsigned SMALL_W    = 14,
  parameter int unsigned XFER_BYTES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             burst_cap_en_i,
  input logic             single_xfer_i,
  input logic             big_buf_i,
  input logic             dma_reset_i,
  input logic             frame_avail_i,
  input logic             dack_i,
  input logic             rd_n_i,
  input logic             dreq_o,
  input logic [OFS_W-1:0] offset_o,
  input logic             buf_clear_o
);
  localparam int unsigned BURST_CYC = CLK_MHZ * BURST_NS / 1000;
  localparam logic [OFS_W-1:0] SMALL_MASK = {{(OFS_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};

  logic rd_q_c;
  logic [31:0] hi_run;
  logic rise_c, fall_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q_c <= 1'b1;
      hi_run <= '0;
    end else begin
      rd_q_c <= rd_n_i;
      hi_run <= (dreq_o && burst_cap_en_i) ? hi_run + 1 : '0;
    end
  end

  assign rise_c = ~rd_q_c & rd_n_i;
  assign fall_c = rd_q_c & ~rd_n_i;

  AST_RESET_ZEROES_OFS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_reset_i |=> (offset_o == '0) && !dreq_o);  // R6
  AST_CLEAR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dma_reset_i) |=> buf_clear_o);  // R6
  AST_OFS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_i && rise_c && !dma_reset_i) |=>
      offset_o == (($past(offset_o) + OFS_W'(XFER_BYTES)) & ($past(big_buf_i) ? {OFS_W{1'b1}} : SMALL_MASK)));  // R9
  AST_OFS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dack_i && rise_c) && !dma_reset_i |=> $stable(offset_o));  // R8
  AST_SINGLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_xfer_i && dack_i && fall_c) |-> !dreq_o);  // R5
  AST_BURST_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run <= BURST_CYC);  // R3
  AST_REQ_NEEDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dreq_o) && !single_xfer_i && !$past(single_xfer_i)) |-> $past(frame_avail_i));  // R10
endmodule

bind rx_dma_req_ctrl rx_dma_req_ctrl_chk #(
  .CLK_MHZ   (CLK_MHZ),
  .BURST_NS  (BURST_NS),
  .OFS_W     (OFS_W),
  .SMALL_W   (SMALL_W),
  .XFER_BYTES(XFER_BYTES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .burst_cap_en_i(burst_cap_en_i),
  .single_xfer_i (single_xfer_i),
  .big_buf_i     (big_buf_i),
  .dma_reset_i   (dma_reset_i),
  .frame_avail_i (frame_avail_i),
  .dack_i        (dack_i),
  .rd_n_i        (rd_n_i),
  .dreq_o        (dreq_o),
  .offset_o      (offset_o),
  .buf_clear_o   (buf_clear_o)
);

// File: tb/rx_dma_req_ctrl_bench.sv
`timescale 1ns/1ps
module rx_dma_req_ctrl_bench;
  localparam int BURST_CYC = 125 * 28000 / 1000;
  localparam int GAP_CYC   = 125 * 1300 / 1000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic burst_cap_en_i = 1'b0, single_xfer_i = 1'b0, big_buf_i = 1'b0;
  logic dma_reset_i = 1'b0, frame_avail_i = 1'b0, frame_end_i = 1'b0;
  logic dack_i = 1'b0, rd_n_i = 1'b1;
  logic dreq_o, buf_clear_o, dma_abort_o;
  logic [15:0] offset_o;

  int checks = 0, failures = 0;
  int exp_ofs = 0;

  always #4 clk_i = ~clk_i;

  rx_dma_req_ctrl u_rx_dma_req_ctrl (.*);

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int next_ofs(input int cur, input bit big);
    return (cur + 2) % (big ? 65536 : 16384);
  endfunction

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  task automatic wait_req();
    while (!dreq_o) step();
  endtask

  task automatic pulse_dma_reset();
    dma_reset_i = 1'b1;
    #1 chk(!dreq_o, "R6 req drop", dreq_o, 0);
    step();
    chk(offset_o == 0, "R6 offset zero", offset_o, 0);
    chk(buf_clear_o, "R6 clear pulse", buf_clear_o, 1);
    dma_reset_i = 1'b0;
    step();
    chk(!buf_clear_o, "R6 clear one cycle", buf_clear_o, 0);
    exp_ofs = 0;
  endtask

  task automatic host_frame(input int n, input bit single);
    single_xfer_i = single;
    frame_avail_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      wait_req();
      dack_i = 1'b1;
      rd_n_i = 1'b0;
      #1;
      if (single) chk(!dreq_o, "R5 drop on fall", dreq_o, 0);
      else        chk(dreq_o, "R2 held in read", dreq_o, 1);
      repeat ($urandom_range(0, 2)) step();
      step();
      rd_n_i = 1'b1;
      exp_ofs = next_ofs(exp_ofs, big_buf_i);
      if (i == n - 1) begin
        frame_end_i = 1'b1;
        frame_avail_i = 1'b0;
      end
      step();
      frame_end_i = 1'b0;
      if (single) dack_i = 1'b0;
      chk(offset_o == exp_ofs, "R8 offset step", offset_o, exp_ofs);
    end
    dack_i = 1'b0;
    chk(!dreq_o, "R2 drop after frame end", dreq_o, 0);
  endtask

  task automatic quick_reads(input int n);
    for (int i = 0; i < n; i++) begin
      rd_n_i = 1'b0;
      step();
      rd_n_i = 1'b1;
      step();
      exp_ofs = next_ofs(exp_ofs, big_buf_i);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed_sink;
    int lo, hi;
    bit all_hi;
    seed_sink = $urandom(32'h5eed_0017);
    repeat (3) step();
    chk(!dreq_o && offset_o == 0 && !buf_clear_o && !dma_abort_o, "R1 reset state",
        {dreq_o, offset_o, buf_clear_o, dma_abort_o}, 0);
    rst_ni = 1'b1;
    step();

    // R10: strobes with no pending frame
    for (int i = 0; i < 10; i++) begin
      dack_i = i[0];
      rd_n_i = i[1];
      step();
      chk(!dreq_o, "R10 no frame no req", dreq_o, 0);
    end
    dack_i = 1'b0;
    rd_n_i = 1'b1;
    step();
    exp_ofs = offset_o;

    // R2 latency
    single_xfer_i = 1'b0;
    frame_avail_i = 1'b1;
    step();
    chk(dreq_o, "R2 rise one cycle", dreq_o, 1);
    host_frame(3, 1'b0);
    host_frame(4, 1'b1);

    // random frames in both modes and sizes
    for (int k = 0; k < 40; k++) begin
      big_buf_i = 1'($urandom_range(0, 1));
      host_frame($urandom_range(1, 12), 1'($urandom_range(0, 1)));
      step();
    end

    // R6 during active request, with abort strobe
    single_xfer_i = 1'b0;
    frame_avail_i = 1'b1;
    wait_req();
    dma_reset_i = 1'b1;
    #1 chk(dma_abort_o, "R6 abort strobe", dma_abort_o, 1);
    dma_reset_i = 1'b0;
    pulse_dma_reset();

    // R7: reset coincides with read completion
    wait_req();
    dack_i = 1'b1;
    quick_reads(3);
    chk(offset_o == exp_ofs, "R8 before collision", offset_o, exp_ofs);
    rd_n_i = 1'b0;
    step();
    rd_n_i = 1'b1;
    dma_reset_i = 1'b1;
    step();
    chk(offset_o == 0, "R7 reset beats step", offset_o, 0);
    dma_reset_i = 1'b0;
    exp_ofs = 0;
    step();

    // R9 wrap at 16K
    big_buf_i = 1'b0;
    wait_req();
    quick_reads(8191);
    chk(offset_o == 16'h3FFE, "R9 16K top", offset_o, 16'h3FFE);
    quick_reads(1);
    chk(offset_o == 0, "R9 16K wrap", offset_o, 0);
    // R9 wrap at 64K
    big_buf_i = 1'b1;
    quick_reads(32767);
    chk(offset_o == 16'hFFFE, "R9 64K top", offset_o, 16'hFFFE);
    quick_reads(1);
    chk(offset_o == 0, "R9 64K wrap", offset_o, 0);
    dack_i = 1'b0;
    pulse_dma_reset();

    // R3 burst cap and release gap
    burst_cap_en_i = 1'b1;
    frame_avail_i = 1'b1;
    dack_i = 1'b1;
    wait_req();
    hi = 0;
    while (dreq_o) begin hi++; step(); end
    chk(hi == BURST_CYC, "R3 burst length", hi, BURST_CYC);
    lo = 0;
    while (!dreq_o) begin lo++; step(); end
    chk(lo == GAP_CYC + 1, "R3 gap length", lo, GAP_CYC + 1);
    dack_i = 1'b0;
    pulse_dma_reset();

    // R4 no cap: request stays up
    burst_cap_en_i = 1'b0;
    frame_avail_i = 1'b1;
    wait_req();
    all_hi = 1'b1;
    for (int i = 0; i < BURST_CYC + 1500; i++) begin
      if (!dreq_o) all_hi = 1'b0;
      step();
    end
    chk(all_hi, "R4 unbroken request", all_hi, 1);
    frame_avail_i = 1'b0;
    pulse_dma_reset();

    finish_run();
  end
endmodule